// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block is a passive observer for a single-data-rate SDRAM command bus. It samples the clock enable, chip select, the three strobes, the two bank bits and address bit 10 on every rising clock edge. It decodes the command, keeps a state and a set of cycle counters for each of four banks, and reports the first rule broken by each command. It never drives the memory bus. It can sit inside a testbench next to a memory model, or be kept on chip as an assertion block that watches a controller.

A command that breaks a rule is reported and then not applied to the tracked bank states. The monitor therefore keeps following the last legal picture of the memory. The error code and the bank states are registered and appear right after the clock edge that sampled the command. There is no data path and no handshake. Every pin is a plain level sampled once per cycle.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only when `cke` was high at the previous sampling edge and `cs_n` is low. From {`ras_n`,`cas_n`,`we_n`}, 000 is mode-register set, 001 is refresh, 011 is activate, 101 is read, 100 is write, 010 is precharge, 110 is burst stop and 111 is no-op. Undecoded cycles raise no error and change no state.
- R2: `ba` value b selects bank b. Bank b's state sits in `bank_state_o[2b+1:2b]`: 0 is idle, 1 is open, 2 is an auto-precharge burst and 3 is precharge recovery. An accepted activate on an idle bank makes it open from the next edge.
- R3: Any decoded command other than no-op, sampled fewer than `T_MRD` edges after an accepted mode-register set, reports code 1.
- R4: A mode-register set or refresh while any bank is not idle reports code 2.
- R5: A read or write with `a10` high to an open bank puts that bank in state 2 for `BURST_LEN` edges, then in state 3 for `T_RP` edges, then idle. A read or write to any bank while some bank is in state 2 reports code 3. Activates to other banks stay legal during that time.
- R6: A read or write to a bank that is not open reports code 4. A read or write fewer than `T_RCD` edges after that bank's activate reports code 5.
- R7: An activate to a bank in state 1 or 2 reports code 6. An activate to a bank in state 3 reports code 7.
- R8: An activate fewer than `T_RC` edges after the previous accepted activate of the same bank reports code 8. An activate to a different bank fewer than `T_RRD` edges after the last accepted activate reports code 9.
- R9: A precharge that would close an open bank fewer than `T_RAS` edges after its activate reports code 10. An accepted precharge moves an open bank to state 3 for `T_RP` edges, then to idle.
- R10: A precharge with `a10` high applies to every open bank, whatever the value of `ba`. Banks in state 0, 2 or 3 are left unchanged.
- R11: A burst stop never reports an error outside the `T_MRD` window and changes no bank state.
- R12: When a command breaks several rules, the lowest-numbered check in the order R3, R4, R5, R6, R7, R8, R9 is reported. A reported command changes no bank state. `err_valid_o` is high exactly when `err_code_o` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Observed clock enable |
| cs_n | input | 1 | Observed chip select, active low |
| ras_n | input | 1 | Observed row strobe |
| cas_n | input | 1 | Observed column strobe |
| we_n | input | 1 | Observed write enable |
| ba | input | 2 | Observed bank select |
| a10 | input | 1 | Observed address bit 10 (auto-precharge / all-banks flag) |
| err_valid_o | output | 1 | High for one cycle per reported violation |
| err_code_o | output | 4 | Code of the broken rule, 0 when none |
| bank_state_o | output | 8 | Two-bit state of each of the four banks |

## Verification
The stimulus starts with cycles that must not decode: a deselected chip and a command issued right after clock enable was low. It then steps through legal and illegal command sequences that land exactly on and one edge short of each spacing limit, so an off-by-one in any counter shows up. Bursts with auto-precharge are run with reads and writes to the same bank and to other banks, and with activates during the burst and during recovery, which separates the lock window from the recovery window. Precharges are issued per bank and for all banks with a bank field that points at an idle bank, which shows that the all-banks flag overrides the bank bits.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MRS, CMD_REF, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_BST
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_OPEN   = 2'd1,
    BK_APBUR  = 2'd2,
    BK_PRECHG = 2'd3
  } bank_st_e;

  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_MRD      = 4'd1,
    ERR_NOT_IDLE = 4'd2,
    ERR_AP_LOCK  = 4'd3,
    ERR_CLOSED   = 4'd4,
    ERR_RCD      = 4'd5,
    ERR_DBL_ACT  = 4'd6,
    ERR_RP       = 4'd7,
    ERR_RC       = 4'd8,
    ERR_RRD      = 4'd9,
    ERR_RAS      = 4'd10
  } err_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd_o
);
  logic cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  always_comb begin
    cmd_o = CMD_NOP;
    if (cke_q && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b000: cmd_o = CMD_MRS;
        3'b001: cmd_o = CMD_REF;
        3'b011: cmd_o = CMD_ACT;
        3'b101: cmd_o = CMD_RD;
        3'b100: cmd_o = CMD_WR;
        3'b010: cmd_o = CMD_PRE;
        3'b110: cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 2,
  parameter int AW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_go,
  input  logic          pre_go,
  input  logic          ap_go,
  output logic [1:0]    st_o,
  output logic [AW-1:0] age_o
);
  localparam int CNT_MAX = (BURST_LEN > T_RP) ? BURST_LEN : T_RP;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [AW-1:0] AGE_SAT = '1;

  bank_st_e      st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= AGE_SAT;
    end else if (act_go) begin
      age_q <= AW'(1);
    end else if (age_q != AGE_SAT) begin
      age_q <= age_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        BK_IDLE: if (act_go) st_q <= BK_OPEN;
        BK_OPEN: begin
          if (ap_go) begin
            st_q  <= BK_APBUR;
            cnt_q <= CW'(BURST_LEN);
          end else if (pre_go) begin
            st_q  <= BK_PRECHG;
            cnt_q <= CW'(T_RP);
          end
        end
        BK_APBUR: begin
          if (cnt_q <= CW'(1)) begin
            st_q  <= BK_PRECHG;
            cnt_q <= CW'(T_RP);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        BK_PRECHG: begin
          if (cnt_q <= CW'(1)) st_q <= BK_IDLE;
          else                 cnt_q <= cnt_q - CW'(1);
        end
        default: st_q <= BK_IDLE;
      endcase
    end
  end

  assign st_o  = st_q;
  assign age_o = age_q;
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BA_W  = 2,
  parameter int AW    = 5,
  parameter int T_RCD = 2,
  parameter int T_RAS = 4,
  parameter int T_RC  = 8
) (
  input  cmd_e                   cmd_i,
  input  logic [BA_W-1:0]        ba_i,
  input  logic                   a10_i,
  input  logic [NB-1:0][1:0]     st_i,
  input  logic [NB-1:0][AW-1:0]  age_i,
  input  logic                   mrd_busy_i,
  input  logic                   rrd_young_i,
  input  logic [BA_W-1:0]        last_ba_i,
  output err_e                   code_o
);
  localparam logic [AW-1:0] RCD_L = AW'(T_RCD);
  localparam logic [AW-1:0] RAS_L = AW'(T_RAS);
  localparam logic [AW-1:0] RC_L  = AW'(T_RC);

  logic          any_busy, any_ap, young_open;
  logic [1:0]    tgt_st;
  logic [AW-1:0] tgt_age;

  always_comb begin
    any_busy   = 1'b0;
    any_ap     = 1'b0;
    young_open = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (st_i[b] != BK_IDLE)  any_busy = 1'b1;
      if (st_i[b] == BK_APBUR) any_ap   = 1'b1;
      if (st_i[b] == BK_OPEN && age_i[b] < RAS_L) young_open = 1'b1;
    end
  end

  assign tgt_st  = st_i[ba_i];
  assign tgt_age = age_i[ba_i];

  always_comb begin
    code_o = ERR_NONE;
    if (cmd_i != CMD_NOP && mrd_busy_i) begin
      code_o = ERR_MRD;
    end else begin
      unique case (cmd_i)
        CMD_MRS, CMD_REF: if (any_busy) code_o = ERR_NOT_IDLE;
        CMD_RD, CMD_WR: begin
          if (any_ap)                  code_o = ERR_AP_LOCK;
          else if (tgt_st != BK_OPEN)  code_o = ERR_CLOSED;
          else if (tgt_age < RCD_L)    code_o = ERR_RCD;
        end
        CMD_ACT: begin
          if (tgt_st == BK_OPEN || tgt_st == BK_APBUR) code_o = ERR_DBL_ACT;
          else if (tgt_st == BK_PRECHG)                code_o = ERR_RP;
          else if (tgt_age < RC_L)                     code_o = ERR_RC;
          else if (last_ba_i != ba_i && rrd_young_i)   code_o = ERR_RRD;
        end
        CMD_PRE: begin
          if (a10_i) begin
            if (young_open) code_o = ERR_RAS;
          end else if (tgt_st == BK_OPEN && tgt_age < RAS_L) begin
            code_o = ERR_RAS;
          end
        end
        default: code_o = ERR_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 4,
  parameter int T_RC      = 8,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic              a10,
  output logic              err_valid_o,
  output logic [3:0]        err_code_o,
  output logic [2*(1<<BA_W)-1:0] bank_state_o
);
  localparam int NB   = 1 << BA_W;
  localparam int M1   = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int M2   = (T_RC > T_RRD) ? T_RC : T_RRD;
  localparam int MAXP = (M1 > M2) ? M1 : M2;
  localparam int AW   = $clog2(MAXP + 1) + 1;
  localparam int MW   = $clog2(T_MRD + 1);
  localparam logic [AW-1:0] AGE_SAT = '1;
  localparam logic [AW-1:0] RRD_L   = AW'(T_RRD);

  cmd_e                  cmd;
  err_e                  code;
  logic                  accept;
  logic [NB-1:0][1:0]    st;
  logic [NB-1:0][AW-1:0] age;
  logic [NB-1:0]         act_go, pre_go, ap_go;
  logic [MW-1:0]         mrd_q;
  logic [AW-1:0]         last_age_q;
  logic [BA_W-1:0]       last_ba_q;
  err_e                  code_q;

  sdram_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_o(cmd)
  );

  sdram_rule_check #(
    .NB(NB), .BA_W(BA_W), .AW(AW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC)
  ) u_rules (
    .cmd_i(cmd), .ba_i(ba), .a10_i(a10), .st_i(st), .age_i(age),
    .mrd_busy_i(mrd_q != '0), .rrd_young_i(last_age_q < RRD_L),
    .last_ba_i(last_ba_q), .code_o(code)
  );

  assign accept = (cmd != CMD_NOP) && (code == ERR_NONE);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign act_go[b] = accept && cmd == CMD_ACT && ba == BA_W'(b);
    assign pre_go[b] = accept && cmd == CMD_PRE && (a10 || ba == BA_W'(b));
    assign ap_go[b]  = accept && (cmd == CMD_RD || cmd == CMD_WR) && a10 && ba == BA_W'(b);

    sdram_bank_track #(.BURST_LEN(BURST_LEN), .T_RP(T_RP), .AW(AW)) u_trk (
      .clk(clk), .rst_n(rst_n), .act_go(act_go[b]), .pre_go(pre_go[b]),
      .ap_go(ap_go[b]), .st_o(st[b]), .age_o(age[b])
    );
    assign bank_state_o[2*b +: 2] = st[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrd_q      <= '0;
      last_age_q <= AGE_SAT;
      last_ba_q  <= '0;
      code_q     <= ERR_NONE;
    end else begin
      code_q <= code;
      if (accept && cmd == CMD_MRS) mrd_q <= MW'(T_MRD - 1);
      else if (mrd_q != '0)         mrd_q <= mrd_q - MW'(1);
      if (accept && cmd == CMD_ACT) begin
        last_age_q <= AW'(1);
        last_ba_q  <= ba;
      end else if (last_age_q != AGE_SAT) begin
        last_age_q <= last_age_q + AW'(1);
      end
    end
  end

  assign err_code_o  = code_q;
  assign err_valid_o = (code_q != ERR_NONE);
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int BA_W = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [BA_W-1:0]           ba,
  input logic                      err_valid_o,
  input logic [3:0]                err_code_o,
  input logic [2*(1<<BA_W)-1:0]    bank_state_o
);
  localparam int NB = 1 << BA_W;
  logic [1:0] tgt_st;
  assign tgt_st = bank_state_o[2*ba +: 2];

  // R4: a not-idle report needs some bank busy before the command
  a_r4_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_code_o == 4'd2 |-> $past(bank_state_o) != '0);

  // R6: a closed-bank report needs the addressed bank not open before
  a_r6_closed_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_code_o == 4'd4 |-> $past(tgt_st) != 2'd1);

  // R5: lock report needs some bank in an auto-precharge burst
  a_r5_lock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_code_o == 4'd3 |-> ($past(bank_state_o[1:0]) == 2'd2 ||
      $past(bank_state_o[3:2]) == 2'd2 || $past(bank_state_o[5:4]) == 2'd2 ||
      $past(bank_state_o[7:6]) == 2'd2));

  for (genvar b = 0; b < NB; b++) begin : g_b
    // R2: a bank opens only from idle
    a_r2_open_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state_o[2*b +: 2] == 2'd1 && $past(bank_state_o[2*b +: 2]) != 2'd1)
        |-> $past(bank_state_o[2*b +: 2]) == 2'd0);
    // R5: an auto-precharge burst starts only from an open bank
    a_r5_burst_from_open: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state_o[2*b +: 2] == 2'd2 && $past(bank_state_o[2*b +: 2]) != 2'd2)
        |-> $past(bank_state_o[2*b +: 2]) == 2'd1);
    // R12: a reported command opens no bank
    a_r12_no_open_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid_o && bank_state_o[2*b +: 2] == 2'd1)
        |-> $past(bank_state_o[2*b +: 2]) == 2'd1);
  end
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BA_W(BA_W)) chk_i (.*);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb_top;
  import sdram_mon_pkg::*;

  localparam int P_RCD = 2, P_RAS = 4, P_RC = 8, P_RRD = 2, P_RP = 2, P_MRD = 2, P_BL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic err_valid_o;
  logic [3:0] err_code_o;
  logic [7:0] bank_state_o;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(.T_RCD(P_RCD), .T_RAS(P_RAS), .T_RC(P_RC), .T_RRD(P_RRD),
    .T_RP(P_RP), .T_MRD(P_MRD), .BURST_LEN(P_BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .err_valid_o(err_valid_o),
    .err_code_o(err_code_o), .bank_state_o(bank_state_o));

  int n_cmp = 0, n_bad = 0;

  // reference model: event times per bank
  int cyc = 0;
  int prev_cke = 0;
  int act_at[4], ap_end[4], rp_end[4];
  bit open_b[4];
  int last_act = -1000, last_bank = 0, mrs_at = -1000;

  function automatic int mst(int b, int c);
    if (c <= ap_end[b]) return 2;
    if (c <= rp_end[b]) return 3;
    if (open_b[b]) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input int got, input int exp, input string what);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic step(input logic k, input logic cs, input cmd_e cm,
                      input int b, input logic a, input string tag);
    int e;
    int expst;
    bit dec;
    cke = k; cs_n = cs; ba = 2'(b); a10 = a;
    case (cm)
      CMD_MRS: {ras_n, cas_n, we_n} = 3'b000;
      CMD_REF: {ras_n, cas_n, we_n} = 3'b001;
      CMD_ACT: {ras_n, cas_n, we_n} = 3'b011;
      CMD_RD:  {ras_n, cas_n, we_n} = 3'b101;
      CMD_WR:  {ras_n, cas_n, we_n} = 3'b100;
      CMD_PRE: {ras_n, cas_n, we_n} = 3'b010;
      CMD_BST: {ras_n, cas_n, we_n} = 3'b110;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    dec = (prev_cke != 0) && !cs && cm != CMD_NOP;
    e = 0;
    if (dec) begin
      if (cyc - mrs_at < P_MRD) e = 1;
      else if (cm == CMD_MRS || cm == CMD_REF) begin
        for (int i = 0; i < 4; i++) if (mst(i, cyc) != 0) e = 2;
      end else if (cm == CMD_RD || cm == CMD_WR) begin
        for (int i = 0; i < 4; i++) if (mst(i, cyc) == 2) e = 3;
        if (e == 0 && mst(b, cyc) != 1) e = 4;
        else if (e == 0 && cyc - act_at[b] < P_RCD) e = 5;
      end else if (cm == CMD_ACT) begin
        if (mst(b, cyc) == 1 || mst(b, cyc) == 2) e = 6;
        else if (mst(b, cyc) == 3) e = 7;
        else if (cyc - act_at[b] < P_RC) e = 8;
        else if (b != last_bank && cyc - last_act < P_RRD) e = 9;
      end else if (cm == CMD_PRE) begin
        for (int i = 0; i < 4; i++)
          if ((a || i == b) && mst(i, cyc) == 1 && cyc - act_at[i] < P_RAS) e = 10;
      end
      if (e == 0) begin
        case (cm)
          CMD_MRS: mrs_at = cyc;
          CMD_ACT: begin open_b[b] = 1; act_at[b] = cyc; last_act = cyc; last_bank = b; end
          CMD_RD, CMD_WR: if (a) begin
            open_b[b] = 0; ap_end[b] = cyc + P_BL; rp_end[b] = cyc + P_BL + P_RP;
          end
          CMD_PRE: for (int i = 0; i < 4; i++)
            if ((a || i == b) && mst(i, cyc) == 1) begin open_b[i] = 0; rp_end[i] = cyc + P_RP; end
          default: ;
        endcase
      end
    end
    prev_cke = k;
    expst = 0;
    for (int i = 0; i < 4; i++) expst |= mst(i, cyc + 1) << (2 * i);
    @(negedge clk);
    check(tag, int'(err_code_o), e, "err_code");
    check(tag, int'(err_valid_o), (e != 0) ? 1 : 0, "err_valid");
    check(tag, int'(bank_state_o), expst, "bank_state");
    cyc++;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      act_at[i] = -1000; ap_end[i] = -1000; rp_end[i] = -1000; open_b[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R2", int'(bank_state_o), 0, "reset bank_state");
    check("R12", int'(err_valid_o), 0, "reset err_valid");
    rst_n = 1'b1;
    // R1: decode gating
    step(1, 1, CMD_NOP, 0, 0, "R1");
    step(1, 1, CMD_ACT, 0, 0, "R1");
    step(0, 0, CMD_NOP, 0, 0, "R1");
    step(1, 0, CMD_ACT, 0, 0, "R1");
    // R3: mode register gap
    step(1, 0, CMD_MRS, 0, 0, "R3");
    step(1, 0, CMD_ACT, 1, 0, "R3");
    step(1, 0, CMD_ACT, 1, 0, "R2");
    // R4: refresh / mode set with open bank
    step(1, 0, CMD_REF, 0, 0, "R4");
    step(1, 0, CMD_RD, 1, 0, "R6");
    step(1, 0, CMD_ACT, 2, 0, "R2");
    step(1, 0, CMD_WR, 2, 0, "R6");
    step(1, 0, CMD_RD, 3, 0, "R6");
    step(1, 0, CMD_ACT, 2, 0, "R7");
    step(1, 0, CMD_ACT, 3, 0, "R8");
    step(1, 0, CMD_ACT, 0, 0, "R8");
    step(1, 0, CMD_PRE, 3, 0, "R9");
    step(1, 0, CMD_NOP, 0, 0, "R9");
    step(1, 0, CMD_PRE, 3, 0, "R9");
    step(1, 0, CMD_ACT, 3, 0, "R7");
    step(1, 0, CMD_NOP, 0, 0, "R9");
    step(1, 0, CMD_ACT, 3, 0, "R8");
    step(1, 0, CMD_ACT, 3, 0, "R8");
    step(1, 0, CMD_BST, 1, 0, "R11");
    // R10: precharge all
    step(1, 0, CMD_PRE, 0, 1, "R10");
    step(1, 0, CMD_NOP, 0, 0, "R10");
    step(1, 0, CMD_NOP, 0, 0, "R10");
    step(1, 0, CMD_PRE, 0, 1, "R10");
    step(1, 0, CMD_MRS, 0, 0, "R4");
    step(1, 0, CMD_NOP, 0, 0, "R10");
    step(1, 0, CMD_ACT, 0, 0, "R2");
    step(1, 0, CMD_NOP, 0, 0, "R2");
    // R5: auto-precharge burst
    step(1, 0, CMD_RD, 0, 1, "R5");
    step(1, 0, CMD_ACT, 1, 0, "R5");
    step(1, 0, CMD_NOP, 0, 0, "R5");
    step(1, 0, CMD_RD, 1, 0, "R5");
    step(1, 0, CMD_WR, 0, 0, "R12");
    step(1, 0, CMD_RD, 1, 0, "R5");
    step(1, 0, CMD_ACT, 0, 0, "R5");
    step(1, 0, CMD_ACT, 0, 0, "R5");
    step(1, 0, CMD_BST, 0, 0, "R11");
    step(1, 0, CMD_PRE, 0, 1, "R10");
    repeat (4) step(1, 0, CMD_NOP, 0, 0, "R9");
    step(1, 0, CMD_MRS, 0, 0, "R3");
    step(1, 0, CMD_BST, 0, 0, "R3");
    step(1, 0, CMD_BST, 0, 0, "R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule